// File: doc/BRIEF.md
# Raster Sync and Interrupt Timing Generator

This block produces the fixed timing skeleton of a raster display. A cycle counter runs across each scanline and a line counter runs down each frame; both advance on every clock with no gaps. From their values the block derives an active-low horizontal sync pulse at the start of each line and an active-low vertical (composite) sync that begins at the top of the frame and ends in the middle of its third line. It also produces a display-enable window that tells downstream fetch and pixel logic when a visible position is current.

An end-of-display interrupt flag is raised once the raster leaves the visible area and is held as a level until the top of the next frame. Software or a controller may drop it earlier with a one-cycle acknowledge. When a raise and an acknowledge arrive in the same cycle, the raise is kept.

The default geometry is 1024 cycles per line and 312 lines per frame. There are 640 visible cycles starting at cycle 256, and 256 visible lines starting at line 28. Every edge of the geometry is a parameter, and the bench uses a scaled-down geometry to cover whole frames. The sync and flag outputs are registered from the counter values, so each one changes one clock after the counter position that triggers it.

Top module: `raster_timing_gen`

## Requirements
- R1: Output x steps by one every clock. From LINE_CYCLES-1 (default 1023) it returns to 0, and in that same clock y steps by one.
- R2: Output y stays constant except when x wraps. From FRAME_LINES-1 (default 311) it returns to 0 together with x.
- R3: hsync_n is 0 exactly while x is in 1..HS_END (default 64), i.e. one clock after x reaches 0 until one clock after x reaches HS_END. Otherwise it is 1.
- R4: csync_n is 0 from position (y=0, x=1) through position (y=VS_LINE, x=VS_CYCLE) inclusive, with defaults VS_LINE=2 and VS_CYCLE=512. It is 1 everywhere else.
- R5: active is 1 exactly when x is in ACT_X_FIRST..ACT_X_FIRST+ACT_X_COUNT-1 (default 256..895) and y is in ACT_Y_FIRST..ACT_Y_FIRST+ACT_Y_COUNT-1 (default 28..283). It is aligned with the x and y values on the same outputs.
- R6: irq_vsync becomes 1 at position (y=ACT_Y_FIRST+ACT_Y_COUNT, x=1), i.e. at (284, 1) by default. With no acknowledge it stays 1 through position (0, 0) and returns to 0 at position (0, 1).
- R7: irq_ack high for one clock while irq_vsync is 1 clears irq_vsync at the next counter position.
- R8: If irq_ack is high in the clock where x=0 and y is the first line below the visible area, irq_vsync is still 1 at the next position. The raise wins over the acknowledge.
- R9: A clock with rst high leaves x=0, y=0, hsync_n=1, csync_n=1, active=0 and irq_vsync=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| hsync_n | output | 1 | Horizontal sync, active low |
| csync_n | output | 1 | Vertical / composite sync, active low |
| x | output | $clog2(LINE_CYCLES) | Cycle position within the scanline |
| y | output | $clog2(FRAME_LINES) | Scanline position within the frame |
| active | output | 1 | Visible-area enable, aligned with x and y |
| irq_vsync | output | 1 | End-of-display interrupt level |

## Verification
The embedded properties check, on every clock, the following:
- the counter stepping and wrapping;
- the start and end edges of both sync pulses;
- that active agrees with the x and y window;
- the raise, frame-top clear and acknowledge behaviour of the interrupt, including the case where raise and acknowledge coincide.

Only the bench scenarios can show the full shape of whole frames. That covers the vertical sync running unbroken across its first lines, the interrupt holding across the bottom margin and the frame wrap, and the exact sequence of positions after reset. The bench follows these against a cycle count taken from reset.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef struct packed {
        logic hs_n;
        logic cs_n;
        logic irq;
    } rtg_flags_t;

    localparam rtg_flags_t RTG_FLAGS_IDLE = '{hs_n: 1'b1, cs_n: 1'b1, irq: 1'b0};

endpackage

// File: rtl/rtg_counter.sv
module rtg_counter #(
    parameter int MAX = 1024,
    parameter int W   = $clog2(MAX)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(MAX - 1);

    always_comb begin
        wrap  = inc && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (inc) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R1 / R2: stepping and wrapping of a position counter
    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_count_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt_q == LAST) |=> (cnt_q == '0));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/rtg_sync_irq.sv
module rtg_sync_irq
    import rtg_pkg::*;
#(
    parameter int XW       = 10,
    parameter int YW       = 9,
    parameter int HS_END   = 64,
    parameter int VS_LINE  = 2,
    parameter int VS_CYCLE = 512,
    parameter int IRQ_LINE = 284
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x_q,
    input  logic [YW-1:0] y_q,
    input  logic          ack,
    output logic          hs_n,
    output logic          cs_n,
    output logic          irq
);
    localparam logic [XW-1:0] HS_STOP_X = XW'(HS_END);
    localparam logic [XW-1:0] VS_STOP_X = XW'(VS_CYCLE);
    localparam logic [YW-1:0] VS_STOP_Y = YW'(VS_LINE);
    localparam logic [YW-1:0] IRQ_Y     = YW'(IRQ_LINE);

    rtg_flags_t flags_q, flags_d;
    logic line_start, frame_start, irq_raise;

    always_comb begin
        line_start  = (x_q == '0);
        frame_start = line_start && (y_q == '0);
        irq_raise   = line_start && (y_q == IRQ_Y);
        flags_d     = flags_q;

        if (line_start)              flags_d.hs_n = 1'b0;
        else if (x_q == HS_STOP_X)   flags_d.hs_n = 1'b1;

        if (frame_start)                                flags_d.cs_n = 1'b0;
        else if (y_q == VS_STOP_Y && x_q == VS_STOP_X)  flags_d.cs_n = 1'b1;

        if (ack)         flags_d.irq = 1'b0;
        if (frame_start) flags_d.irq = 1'b0;
        if (irq_raise)   flags_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= RTG_FLAGS_IDLE;
        else     flags_q <= flags_d;
    end

    assign hs_n = flags_q.hs_n;
    assign cs_n = flags_q.cs_n;
    assign irq  = flags_q.irq;

    assert_hs_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (x_q == '0) |=> !hs_n);
    assert_hs_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (x_q == HS_STOP_X) |=> hs_n);
    assert_cs_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (x_q == '0 && y_q == '0) |=> !cs_n);
    assert_cs_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (x_q == VS_STOP_X && y_q == VS_STOP_Y) |=> cs_n);
    assert_irq_clear_top_R6: assert property (@(posedge clk) disable iff (rst)
        (x_q == '0 && y_q == '0) |=> !irq);
    assert_irq_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && !(x_q == '0 && y_q == IRQ_Y)) |=> !irq);
    assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (x_q == '0 && y_q == IRQ_Y) |=> irq);
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
    parameter int XW          = 10,
    parameter int YW          = 9,
    parameter int ACT_X_FIRST = 256,
    parameter int ACT_X_COUNT = 640,
    parameter int ACT_Y_FIRST = 28,
    parameter int ACT_Y_COUNT = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x_d,
    input  logic [YW-1:0] y_d,
    output logic          active_q
);
    localparam logic [XW-1:0] X_LO = XW'(ACT_X_FIRST);
    localparam logic [XW-1:0] X_HI = XW'(ACT_X_FIRST + ACT_X_COUNT - 1);
    localparam logic [YW-1:0] Y_LO = YW'(ACT_Y_FIRST);
    localparam logic [YW-1:0] Y_HI = YW'(ACT_Y_FIRST + ACT_Y_COUNT - 1);

    logic active_d;

    always_comb begin
        active_d = (x_d >= X_LO) && (x_d <= X_HI) && (y_d >= Y_LO) && (y_d <= Y_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active_d;
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int LINE_CYCLES = 1024,
    parameter int FRAME_LINES = 312,
    parameter int HS_END      = 64,
    parameter int VS_LINE     = 2,
    parameter int VS_CYCLE    = 512,
    parameter int ACT_X_FIRST = 256,
    parameter int ACT_X_COUNT = 640,
    parameter int ACT_Y_FIRST = 28,
    parameter int ACT_Y_COUNT = 256,
    parameter int XW          = $clog2(LINE_CYCLES),
    parameter int YW          = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_ack,
    output logic          hsync_n,
    output logic          csync_n,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          active,
    output logic          irq_vsync
);
    localparam int IRQ_LINE = ACT_Y_FIRST + ACT_Y_COUNT;
    localparam logic [XW-1:0] X_LO = XW'(ACT_X_FIRST);
    localparam logic [XW-1:0] X_HI = XW'(ACT_X_FIRST + ACT_X_COUNT - 1);
    localparam logic [YW-1:0] Y_LO = YW'(ACT_Y_FIRST);
    localparam logic [YW-1:0] Y_HI = YW'(ACT_Y_FIRST + ACT_Y_COUNT - 1);

    logic [XW-1:0] x_d;
    logic [YW-1:0] y_d;
    logic          x_wrap, y_wrap;

    rtg_counter #(.MAX(LINE_CYCLES), .W(XW)) u_xcnt (
        .clk(clk), .rst(rst), .inc(1'b1),
        .cnt_q(x), .cnt_d(x_d), .wrap(x_wrap)
    );

    rtg_counter #(.MAX(FRAME_LINES), .W(YW)) u_ycnt (
        .clk(clk), .rst(rst), .inc(x_wrap),
        .cnt_q(y), .cnt_d(y_d), .wrap(y_wrap)
    );

    rtg_sync_irq #(
        .XW(XW), .YW(YW), .HS_END(HS_END), .VS_LINE(VS_LINE),
        .VS_CYCLE(VS_CYCLE), .IRQ_LINE(IRQ_LINE)
    ) u_sync (
        .clk(clk), .rst(rst), .x_q(x), .y_q(y), .ack(irq_ack),
        .hs_n(hsync_n), .cs_n(csync_n), .irq(irq_vsync)
    );

    rtg_window #(
        .XW(XW), .YW(YW), .ACT_X_FIRST(ACT_X_FIRST), .ACT_X_COUNT(ACT_X_COUNT),
        .ACT_Y_FIRST(ACT_Y_FIRST), .ACT_Y_COUNT(ACT_Y_COUNT)
    ) u_win (
        .clk(clk), .rst(rst), .x_d(x_d), .y_d(y_d), .active_q(active)
    );

    // R5: enable matches the window of the reported position
    assert_active_window_R5: assert property (@(posedge clk) disable iff (rst)
        active == ((x >= X_LO) && (x <= X_HI) && (y >= Y_LO) && (y <= Y_HI)));
    // R2: frame wrap returns both counters to the origin
    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        y_wrap |=> (x == '0 && y == '0));
    // R9: reset state
    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (x == '0 && y == '0 && hsync_n && csync_n && !active && !irq_vsync));
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
    localparam int LW   = 128;
    localparam int FL   = 40;
    localparam int HSE  = 8;
    localparam int VSL  = 2;
    localparam int VSX  = 64;
    localparam int AX0  = 32;
    localparam int AXN  = 80;
    localparam int AY0  = 4;
    localparam int AYN  = 32;
    localparam int IRQL = AY0 + AYN;
    localparam int XW   = $clog2(LW);
    localparam int YW   = $clog2(FL);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_ack = 1'b0;
    logic hsync_n, csync_n, active, irq_vsync;
    logic [XW-1:0] x;
    logic [YW-1:0] y;

    int n_checks = 0;
    int n_fail   = 0;
    int k        = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    raster_timing_gen #(
        .LINE_CYCLES(LW), .FRAME_LINES(FL), .HS_END(HSE), .VS_LINE(VSL),
        .VS_CYCLE(VSX), .ACT_X_FIRST(AX0), .ACT_X_COUNT(AXN),
        .ACT_Y_FIRST(AY0), .ACT_Y_COUNT(AYN)
    ) u0 (
        .clk(clk), .rst(rst), .irq_ack(irq_ack), .hsync_n(hsync_n),
        .csync_n(csync_n), .x(x), .y(y), .active(active), .irq_vsync(irq_vsync)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        k++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        irq_ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        k = 0;
    endtask

    function automatic int ex(int kk);  return kk % LW; endfunction
    function automatic int ey(int kk);  return (kk / LW) % FL; endfunction
    function automatic int exp_hs(int kk);
        if (kk == 0) return 1;
        return (ex(kk) >= 1 && ex(kk) <= HSE) ? 0 : 1;
    endfunction
    function automatic int exp_cs(int kk);
        int xx = ex(kk), yy = ey(kk);
        if (kk == 0) return 1;
        if ((yy == 0 && xx >= 1) || (yy > 0 && yy < VSL) || (yy == VSL && xx <= VSX)) return 0;
        return 1;
    endfunction
    function automatic int exp_act(int kk);
        int xx = ex(kk), yy = ey(kk);
        return (xx >= AX0 && xx < AX0 + AXN && yy >= AY0 && yy < AY0 + AYN) ? 1 : 0;
    endfunction
    function automatic int exp_irq(int kk);
        int xx = ex(kk), yy = ey(kk);
        if (kk < IRQL * LW + 1) return 0;
        return (yy > IRQL || (yy == IRQL && xx >= 1) || (yy == 0 && xx == 0)) ? 1 : 0;
    endfunction

    // R9: state held in reset and just after release
    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 x", int'(x), 0);
        chk("R9 y", int'(y), 0);
        chk("R9 hsync_n", int'(hsync_n), 1);
        chk("R9 csync_n", int'(csync_n), 1);
        chk("R9 active", int'(active), 0);
        chk("R9 irq_vsync", int'(irq_vsync), 0);
    endtask

    // R1..R6: two whole frames followed position by position
    task automatic t_frames();
        do_reset();
        for (int i = 0; i < 2 * LW * FL + 5; i++) begin
            chk("R1 x", int'(x), ex(k));
            chk("R2 y", int'(y), ey(k));
            chk("R3 hsync_n", int'(hsync_n), exp_hs(k));
            chk("R4 csync_n", int'(csync_n), exp_cs(k));
            chk("R5 active", int'(active), exp_act(k));
            chk("R6 irq_vsync", int'(irq_vsync), exp_irq(k));
            tick();
        end
    endtask

    task automatic advance_to(input int yy, input int xx);
        while (!(int'(x) == xx && int'(y) == yy)) tick();
    endtask

    // R7: acknowledge drops the flag inside the bottom margin
    task automatic t_ack();
        do_reset();
        advance_to(IRQL, 20);
        chk("R7 irq before ack", int'(irq_vsync), 1);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R7 irq after ack", int'(irq_vsync), 0);
        advance_to(IRQL + 1, 0);
        chk("R7 irq stays clear", int'(irq_vsync), 0);
        advance_to(0, 1);
        chk("R7 irq clear at top", int'(irq_vsync), 0);
        chk("R7 hsync_n unaffected", int'(hsync_n), 0);
    endtask

    // R8: raise and acknowledge in the same clock
    task automatic t_set_wins();
        do_reset();
        advance_to(IRQL, 0);
        chk("R8 irq before raise", int'(irq_vsync), 0);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R8 irq raised despite ack", int'(irq_vsync), 1);
        tick();
        chk("R8 irq still held", int'(irq_vsync), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_frames();
        t_ack();
        t_set_wins();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule